// File: doc/BRIEF.md
# Key Event Queue with Interrupt

This block sits between a key-matrix scanner and a host register port. Each time the scanner presents a debounced key vector with a latch strobe, the block compares it with the last key state it accepted. Every key that changed becomes one event byte. The pending events are held as a mask of changed keys. They are handed to the host one at a time, lowest key code first. Each read pulse retires the event currently shown.

An active-low interrupt falls when a batch of events is stored. It rises again once the last event has been read. A 2-bit configuration can also end the interrupt after a fixed delay, measured in milliseconds from the moment it fell. An auto-clear does not drop the stored events: they stay readable until a later latch brings new changes and replaces the whole batch. While the interrupt is low, latch strobes are ignored.

Top module: `kq_evt_queue`

## Requirements
- R1: The event byte shows three fields. Bit 7 is 1 when at least one further event is pending after the one shown. Bit 6 is 1 for a press (key now 1) and 0 for a release (key now 0). Bits 5:0 hold the key code.
- R2: Bit number (column index × 8 + row index) of the key vector belongs to the key at that row and column, and this number is the key code reported for that key. For example, row 1 with column 3 is bit 25 and is reported as code 011001.
- R3: Pending events are shown in strictly ascending key-code order. Each read pulse advances to the next event, and the new event is visible on the cycle after the pulse.
- R4: On the cycle after the last pending event is read, the event byte is 0x00 and irq_n is high.
- R5: A latch strobe while irq_n is high and the vector differs from the accepted state stores the events and drives irq_n low on the next cycle. A strobe whose vector equals the accepted state changes neither the event byte nor irq_n.
- R6: The auto-clear code selects the delay after irq_n falls: 01 gives 5×TICKS_PER_MS cycles and 10 gives 10×TICKS_PER_MS cycles, after which irq_n returns high. With codes 00 and 11, irq_n never returns high on its own.
- R7: After an auto-clear the stored events stay readable. A later latch with changes replaces all of them with the new batch only.
- R8: A latch strobe while irq_n is low is ignored. The event byte stays the same, and the accepted key state is not updated.
- R9: A read pulse while no event is pending returns 0x00 and has no effect.
- R10: After reset the event byte is 0x00, irq_n is high, and all keys count as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_vld | input | 1 | One-cycle strobe: latch_keys holds a new validated state |
| latch_keys | input | ROWS*COLS | Key vector, bit col*8+row, 1 = pressed |
| rd_pulse | input | 1 | One-cycle host read of the event register |
| aci_cfg | input | 2 | Auto-clear select: 00/11 off, 01 short, 10 long |
| evt_byte | output | 8 | Current event byte, 0x00 when none pending |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Every result is one register stage from its cause. After an accepted strobe, the event byte and irq_n are due on the first clock edge. After a read pulse, the next byte (or 0x00 with irq_n high) is also due on the first edge. After a timed auto-clear, irq_n rises exactly 5 or 10 ms worth of cycles after the edge on which it fell. The bench drives inputs on falling edges and samples on the next falling edge. It checks irq_n one cycle before the auto-clear deadline and again on the deadline, so a delay that is one cycle early or late is caught.

// File: rtl/kq_pkg.sv
package kq_pkg;
  localparam int EVT_W  = 8;
  localparam int CODE_F = 6;

  typedef logic [EVT_W-1:0] evt_t;

  typedef enum logic [1:0] {
    ACI_OFF   = 2'b00,
    ACI_SHORT = 2'b01,
    ACI_LONG  = 2'b10,
    ACI_RSVD  = 2'b11
  } aci_e;

  function automatic evt_t pack_evt(input logic more, input logic pressed,
                                    input logic [CODE_F-1:0] code);
    return {more, pressed, code};
  endfunction
endpackage

// File: rtl/kq_diff.sv
module kq_diff #(
  parameter int NKEYS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NKEYS-1:0] keys,
  output logic [NKEYS-1:0] state_q,
  output logic [NKEYS-1:0] delta
);
  logic [NKEYS-1:0] state_d;

  always_comb begin
    delta   = keys ^ state_q;
    state_d = state_q;
    if (load) state_d = keys;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else if (load) state_q <= state_d;
  end
endmodule

// File: rtl/kq_pick.sv
module kq_pick #(
  parameter int NKEYS  = 64,
  parameter int CODE_W = $clog2(NKEYS)
) (
  input  logic [NKEYS-1:0]  mask,
  output logic [NKEYS-1:0]  first_oh,
  output logic [CODE_W-1:0] idx,
  output logic              any,
  output logic              more
);
  logic [NKEYS:0] below;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NKEYS; g++) begin : g_chain
      assign below[g+1]  = below[g] | mask[g];
      assign first_oh[g] = mask[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (first_oh[i]) idx = idx | CODE_W'(i);
    end
  end

  assign any  = below[NKEYS];
  assign more = |(mask & ~first_oh);
endmodule

// File: rtl/kq_timer.sv
module kq_timer #(
  parameter int TICKS_PER_MS = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [1:0] aci,
  output logic       expire
);
  import kq_pkg::*;

  localparam int LONG_CYC = 10 * TICKS_PER_MS;
  localparam int CNT_W    = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] TGT_S = CNT_W'(5 * TICKS_PER_MS - 1);
  localparam logic [CNT_W-1:0] TGT_L = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             armed;
  logic [CNT_W-1:0] tgt;

  always_comb begin
    armed = 1'b0;
    tgt   = TGT_L;
    case (aci_e'(aci))
      ACI_SHORT: begin armed = 1'b1; tgt = TGT_S; end
      ACI_LONG:  begin armed = 1'b1; tgt = TGT_L; end
      default:   begin armed = 1'b0; tgt = TGT_L; end
    endcase
    expire = run & armed & (cnt_q == tgt);
  end

  always_comb begin
    cnt_en = start | (run & (cnt_q != CNT_MAX));
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (cnt_q >= TGT_S)); // R6
endmodule

// File: rtl/kq_evt_queue.sv
module kq_evt_queue #(
  parameter int ROWS         = 8,
  parameter int COLS         = 8,
  parameter int TICKS_PER_MS = 200000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 latch_vld,
  input  logic [ROWS*COLS-1:0] latch_keys,
  input  logic                 rd_pulse,
  input  logic [1:0]           aci_cfg,
  output logic [7:0]           evt_byte,
  output logic                 irq_n
);
  import kq_pkg::*;

  localparam int NKEYS  = ROWS * COLS;
  localparam int CODE_W = $clog2(NKEYS);

  logic [NKEYS-1:0]  state_q, delta;
  logic [NKEYS-1:0]  pend_q, pend_d;
  logic [NKEYS-1:0]  first_oh;
  logic [CODE_W-1:0] idx;
  logic              any, more;
  logic              irq_q, irq_d;
  logic              acc, new_batch, rd_hit, expire;
  logic              pend_en, irq_en;

  kq_diff #(.NKEYS(NKEYS)) u_diff (
    .clk(clk), .rst_n(rst_n), .load(acc), .keys(latch_keys),
    .state_q(state_q), .delta(delta)
  );

  kq_pick #(.NKEYS(NKEYS), .CODE_W(CODE_W)) u_pick (
    .mask(pend_q), .first_oh(first_oh), .idx(idx), .any(any), .more(more)
  );

  kq_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(new_batch), .run(irq_q),
    .aci(aci_cfg), .expire(expire)
  );

  always_comb begin
    acc       = latch_vld & ~irq_q;
    new_batch = acc & (|delta);
    rd_hit    = rd_pulse & any & ~new_batch;

    pend_en = new_batch | rd_hit;
    pend_d  = new_batch ? delta : (pend_q & ~first_oh);

    irq_en = 1'b0;
    irq_d  = irq_q;
    if (new_batch) begin
      irq_en = 1'b1;
      irq_d  = 1'b1;
    end else if ((rd_hit & ~more) | expire) begin
      irq_en = 1'b1;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (irq_en)  irq_q  <= irq_d;
    end
  end

  assign evt_byte = any ? pack_evt(more, state_q[idx], CODE_F'(idx)) : '0;
  assign irq_n    = ~irq_q;

  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_vld && irq_n && (|delta)) |=> !irq_n); // R5

  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && evt_byte[7] && !(latch_vld && irq_n))
      |=> (evt_byte != 8'h00) && (evt_byte[5:0] > $past(evt_byte[5:0]))); // R3

  AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && (evt_byte != 8'h00) && !evt_byte[7] && !(latch_vld && irq_n))
      |=> (evt_byte == 8'h00) && irq_n); // R4

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_vld && !irq_n && !rd_pulse) |=> $stable(evt_byte)); // R8

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && (evt_byte == 8'h00) && !(latch_vld && irq_n))
      |=> (evt_byte == 8'h00)); // R9
endmodule

// File: tb/kq_evt_queue_bench.sv
`timescale 1ns/1ps
module kq_evt_queue_bench;
  localparam int TPM = 4;
  localparam int L_S = 5 * TPM;
  localparam int L_L = 10 * TPM;

  logic        clk, rst_n, latch_vld, rd_pulse;
  logic [63:0] latch_keys;
  logic [1:0]  aci_cfg;
  logic [7:0]  evt_byte;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // table entry: {keys[63:0], event count[7:0], first byte[7:0]}
  localparam logic [79:0] TBL [6] = '{
    {64'h0000_0000_0200_0000, 8'd1,  8'h59},
    {64'h0000_0000_0000_0000, 8'd1,  8'h19},
    {64'h0800_0004_0000_0000, 8'd2,  8'hE2},
    {64'h0800_0000_0000_0000, 8'd1,  8'h22},
    {64'hFFFF_FFFF_FFFF_FFFF, 8'd63, 8'hC0},
    {64'h0000_0000_0000_0000, 8'd64, 8'h80}
  };

  kq_evt_queue #(.ROWS(8), .COLS(8), .TICKS_PER_MS(TPM)) u_kq_evt_queue (
    .clk(clk), .rst_n(rst_n), .latch_vld(latch_vld), .latch_keys(latch_keys),
    .rd_pulse(rd_pulse), .aci_cfg(aci_cfg), .evt_byte(evt_byte), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_latch(logic [63:0] k);
    @(negedge clk); latch_vld = 1'b1; latch_keys = k;
    @(negedge clk); latch_vld = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_pulse = 1'b1;
    @(negedge clk); rd_pulse = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev, k, d;
    logic        more;
    rst_n = 1'b0; latch_vld = 1'b0; rd_pulse = 1'b0;
    latch_keys = '0; aci_cfg = 2'b00;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R10 reset byte", evt_byte, 8'h00);
    check("R10 reset irq_n", {7'b0, irq_n}, 8'h01);

    // table walk: R1 R2 R3 R4 R5
    prev = '0;
    for (int t = 0; t < 6; t++) begin
      int n;
      k = TBL[t][79:16];
      d = k ^ prev;
      do_latch(k);
      check("R5 irq low after latch", {7'b0, irq_n}, 8'h00);
      check("R1 R2 first byte", evt_byte, TBL[t][7:0]);
      n = 0;
      for (int b = 0; b < 64; b++) begin
        if (d[b]) begin
          more = ((d >> b) >> 1) != 64'h0;
          check("R3 ordered event", evt_byte, {more, k[b], 6'(b)});
          if (n > 0) check("R3 irq held", {7'b0, irq_n}, 8'h00);
          n++;
          do_read();
        end
      end
      check("R1 event count", 8'(n), TBL[t][15:8]);
      check("R4 byte after last", evt_byte, 8'h00);
      check("R4 irq after last", {7'b0, irq_n}, 8'h01);
      prev = k;
    end

    // R5 no-change latch
    do_latch(64'h0);
    check("R5 no change irq", {7'b0, irq_n}, 8'h01);
    check("R5 no change byte", evt_byte, 8'h00);

    // R9 empty read
    do_read();
    check("R9 empty read byte", evt_byte, 8'h00);
    check("R9 empty read irq", {7'b0, irq_n}, 8'h01);

    // R6 R7 short auto-clear, then overwrite
    aci_cfg = 2'b01;
    do_latch(64'h0000_0000_0000_0220);
    check("R7 batch first", evt_byte, 8'hC5);
    idle(L_S - 1);
    check("R6 short before deadline", {7'b0, irq_n}, 8'h00);
    idle(1);
    check("R6 short at deadline", {7'b0, irq_n}, 8'h01);
    check("R7 kept after clear", evt_byte, 8'hC5);
    do_latch(64'h0000_0000_0000_1220);
    check("R7 overwrite byte", evt_byte, 8'h4C);
    check("R7 overwrite irq", {7'b0, irq_n}, 8'h00);
    do_read();
    check("R7 old batch gone", evt_byte, 8'h00);
    check("R4 irq after overwrite read", {7'b0, irq_n}, 8'h01);

    // R6 long auto-clear
    aci_cfg = 2'b10;
    do_latch(64'h0000_0000_0010_1220);
    check("R6 long byte", evt_byte, 8'h54);
    idle(L_L - 1);
    check("R6 long before deadline", {7'b0, irq_n}, 8'h00);
    idle(1);
    check("R6 long at deadline", {7'b0, irq_n}, 8'h01);
    do_read();
    check("R4 long read", evt_byte, 8'h00);

    // R6 code 11 never clears; R8 latch while busy
    aci_cfg = 2'b11;
    do_latch(64'h0000_0000_4010_1220);
    check("R6 code11 byte", evt_byte, 8'h5E);
    idle(3 * L_L);
    check("R6 code11 holds", {7'b0, irq_n}, 8'h00);
    do_latch(64'h0);
    check("R8 busy latch ignored", evt_byte, 8'h5E);
    check("R8 busy irq", {7'b0, irq_n}, 8'h00);
    do_read();
    check("R4 code11 read", {7'b0, irq_n}, 8'h01);
    do_latch(64'h0000_0000_4010_1220);
    check("R8 state not updated", {7'b0, irq_n}, 8'h01);
    check("R8 state not updated byte", evt_byte, 8'h00);
    aci_cfg = 2'b00;
    do_latch(64'h0);
    check("R1 release batch", evt_byte, 8'h85);

    // R10 reset mid-batch
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R10 reset clears byte", evt_byte, 8'h00);
    check("R10 reset clears irq", {7'b0, irq_n}, 8'h01);
    do_latch(64'h0);
    check("R10 released after reset", {7'b0, irq_n}, 8'h01);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule